// File: doc/BRIEF.md
# Two-Wire Converter Readout Sequencer

This block sits on the host side of a two-wire link to a delta-sigma converter. One wire, driven by the converter, is a shared ready/data line: it falls when a conversion result is waiting and then carries the result bits. The other wire is a serial clock that the host drives. The sequencer accepts one command at a time. It waits for the ready/data line to fall and then issues a train of clock pulses. It captures the 20-bit two's complement result, most significant bit first, and delivers it sign-extended on a one-cycle valid strobe.

The command selects what happens after the data bits. A plain read adds one extra pulse that returns the line high. A read with calibration adds a second extra pulse and then waits for the converter to signal that it is done. A read with sleep holds the clock high right after the data bits, which powers the converter down, and then pulls the clock low to wake it. A read with calibration on wake sends both extra pulses and holds the last one high for the requested time. In every mode except the plain read, the sequencer watches for the line to fall again. If the line does not fall within a parameterised number of cycles, it flags a timeout.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: A command is accepted only while `cmd_ready` is high, and `cmd_ready` is high only while the serial clock is low. After a command is accepted, the first rising edge of `sclk_out` comes only after `sdo_in` has been seen low.
- R2: Every clock pulse has a high phase of HALF system clocks, and the gap between consecutive pulses is HALF system clocks. The one exception is the held last pulse of the two sleep modes.
- R3: The line is sampled at the end of the high phase of pulses 1 to 20, first sample as the most significant bit. `res_valid` pulses for exactly one cycle per read. At that pulse, `res_data` holds the 20-bit value sign-extended to 32 bits (bit 19 copied into bits 31..20).
- R4: Mode code 0 (plain read) issues exactly 25 pulses. `cmd_ready` rises in the same cycle as the last falling edge, and no line fall is awaited.
- R5: Mode code 1 (read plus calibration) issues exactly 26 pulses. After the last falling edge, `cmd_ready` stays low until `sdo_in` is seen low.
- R6: Mode code 2 (read plus sleep) issues exactly 21 pulses. The 21st pulse stays high for `cmd_hold` system clocks, or one clock if `cmd_hold` is zero. The sequencer then drives the clock low and waits for `sdo_in` to fall.
- R7: Mode code 3 (calibration on wake) issues exactly 26 pulses. The 26th pulse stays high for `cmd_hold` system clocks, or one clock if `cmd_hold` is zero. The sequencer then waits for `sdo_in` to fall.
- R8: In modes 1 to 3, if `sdo_in` stays high for TIMEOUT cycles after the last falling edge, `timeout_err` is set and the sequencer returns to idle. `timeout_err` is cleared when the next command is accepted.
- R9: During and right after reset, `sclk_out`, `res_valid` and `timeout_err` are low, `cmd_ready` is high, and `res_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is high |
| cmd_mode | input | 2 | 0 plain, 1 calibrate, 2 sleep, 3 calibrate on wake |
| cmd_hold | input | HOLD_W | Clock-high hold time for modes 2 and 3, in system clocks |
| cmd_ready | output | 1 | Idle and able to take a command |
| sdo_in | input | 1 | Ready/data line from the converter |
| sclk_out | output | 1 | Serial clock to the converter |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | RES_W | Sign-extended result |
| timeout_err | output | 1 | Line did not fall after wake or calibration |

## Verification
In plain mode, the last falling clock edge and the return to readiness happen in the same cycle. In the calibrate modes, the same falling edge instead starts the wait for the line. The bench runs every mode over a sweep of result words. At the observation point where the clock is first seen low after the last pulse, it checks `cmd_ready` and the line level together: ready must already be high in mode 0 and must still be low in modes 1 to 3. A converter model that never finishes its calibration makes the timeout expire. The bench then checks that the error flag appears with readiness and clears when the next command is accepted.

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl #(
  parameter int DATA_W  = 20,
  parameter int FRAME_W = 24,
  parameter int HALF    = 4,
  parameter int HOLD_W  = 16,
  parameter int TIMEOUT = 1000000,
  parameter int RES_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_mode,
  input  logic [HOLD_W-1:0] cmd_hold,
  output logic              cmd_ready,
  input  logic              sdo_in,
  output logic              sclk_out,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic              timeout_err
);
  localparam int TW    = $clog2(TIMEOUT + 1);
  localparam int CNT_W = ((TW > HOLD_W) ? TW : HOLD_W) + 1;
  localparam int PW    = $clog2(FRAME_W + 3);
  localparam logic [1:0] M_PLAIN = 2'd0;
  localparam logic [1:0] M_SLEEP = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_LOW, S_HIGH, S_SETTLE} st_t;

  st_t               st;
  logic [1:0]        mode;
  logic [HOLD_W-1:0] hold;
  logic [CNT_W-1:0]  cnt;
  logic [PW-1:0]     pidx;
  logic [DATA_W-1:0] shreg;

  wire [PW-1:0] last = (mode == M_SLEEP) ? PW'(DATA_W + 1) :
                       (mode == M_PLAIN) ? PW'(FRAME_W + 1) : PW'(FRAME_W + 2);
  wire on_last = (pidx == last);
  wire parked  = mode[1] && on_last;
  wire [CNT_W-1:0] hi_len = !parked ? CNT_W'(HALF) :
                            (hold == '0) ? CNT_W'(1) : CNT_W'(hold);
  wire lo_done = (cnt == CNT_W'(HALF - 1));
  wire hi_done = (cnt == hi_len - CNT_W'(1));
  wire tmo_hit = (cnt == CNT_W'(TIMEOUT - 1));

  assign cmd_ready = (st == S_IDLE);
  assign res_data  = {{(RES_W-DATA_W){shreg[DATA_W-1]}}, shreg};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      mode        <= M_PLAIN;
      hold        <= '0;
      cnt         <= '0;
      pidx        <= '0;
      shreg       <= '0;
      sclk_out    <= 1'b0;
      res_valid   <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          mode        <= cmd_mode;
          hold        <= cmd_hold;
          timeout_err <= 1'b0;
          st          <= S_ARM;
        end
        S_ARM: if (!sdo_in) begin
          cnt  <= '0;
          pidx <= PW'(1);
          st   <= S_LOW;
        end
        S_LOW: if (lo_done) begin
          sclk_out <= 1'b1;
          cnt      <= '0;
          st       <= S_HIGH;
        end else cnt <= cnt + CNT_W'(1);
        S_HIGH: if (hi_done) begin
          sclk_out <= 1'b0;
          cnt      <= '0;
          if (pidx <= PW'(DATA_W)) shreg <= {shreg[DATA_W-2:0], sdo_in};
          if (pidx == PW'(DATA_W)) res_valid <= 1'b1;
          if (on_last) st <= (mode == M_PLAIN) ? S_IDLE : S_SETTLE;
          else begin
            pidx <= pidx + PW'(1);
            st   <= S_LOW;
          end
        end else cnt <= cnt + CNT_W'(1);
        S_SETTLE: if (!sdo_in) st <= S_IDLE;
          else if (tmo_hit) begin
            timeout_err <= 1'b1;
            st          <= S_IDLE;
          end else cnt <= cnt + CNT_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module adc_rdout_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       sdo_in,
  input logic       sclk_out,
  input logic       res_valid,
  input logic       timeout_err,
  input logic [2:0] st
);
  localparam logic [2:0] C_IDLE = 3'd0, C_ARM = 3'd1, C_LOW = 3'd2, C_SETTLE = 3'd4;

  p_idle_clock_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !sclk_out);

  p_start_after_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == C_ARM && st == C_LOW) |-> !$past(sdo_in));

  p_gap_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_out) && st == C_LOW) |=> !sclk_out);

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_settle_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == C_SETTLE && st == C_IDLE) |-> (!$past(sdo_in) || timeout_err));

  p_err_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !timeout_err);
endmodule

bind adc_rdout_ctrl adc_rdout_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .sdo_in(sdo_in), .sclk_out(sclk_out), .res_valid(res_valid),
  .timeout_err(timeout_err), .st(st)
);

// File: tb/test_adc_rdout_ctrl.sv
module test_adc_rdout_ctrl;
  localparam int HALF = 4, TMO = 300, CONV = 30, CAL = 40, SLP = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_valid, cmd_ready, sclk_out, res_valid, timeout_err;
  logic [1:0]  cmd_mode;
  logic [15:0] cmd_hold;
  logic [31:0] res_data;
  logic        sdo;

  adc_rdout_ctrl #(.HALF(HALF), .TIMEOUT(TMO)) i_adc_rdout_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_hold(cmd_hold), .cmd_ready(cmd_ready), .sdo_in(sdo), .sclk_out(sclk_out),
    .res_valid(res_valid), .res_data(res_data), .timeout_err(timeout_err));

  int checks = 0, fails = 0;
  logic        mute;
  logic [19:0] next_word;

  // converter model
  int ecnt, hic, cd;
  logic sck_q, sleeping, wcal;
  logic [23:0] frame;
  always @(posedge clk) begin
    if (!rst_n) begin
      sdo <= 1'b1; ecnt <= 0; hic <= 0; cd <= CONV; sck_q <= 1'b0;
      sleeping <= 1'b0; wcal <= 1'b0; frame <= '0;
    end else begin
      sck_q <= sclk_out;
      if (cd > 1) cd <= cd - 1;
      else if (cd == 1 && !mute) begin cd <= 0; sdo <= 1'b0; ecnt <= 0; end
      if (sclk_out && !sck_q) begin
        ecnt <= ecnt + 1; hic <= 1;
        if (ecnt == 0) begin frame <= {next_word, 4'b0}; sdo <= next_word[19]; end
        else if (ecnt < 24) sdo <= frame[23-ecnt];
        else sdo <= 1'b1;
      end else if (sclk_out) begin
        hic <= hic + 1;
        if (hic == SLP && !sleeping) begin
          sleeping <= 1'b1; sdo <= 1'b1; wcal <= (ecnt >= 26); cd <= 0;
        end
      end else if (sck_q) begin
        if (sleeping) begin sleeping <= 1'b0; cd <= wcal ? CAL : CONV; end
        else if (ecnt == 26) cd <= CAL;
        else if (ecnt == 25) cd <= CONV;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] pat(input int i);
    case (i)
      20: pat = 20'h00000; 21: pat = 20'hFFFFF; 22: pat = 20'h7FFFF;
      23: pat = 20'h80000; 24: pat = 20'h55555; 25: pat = 20'hAAAAA;
      default: pat = 20'(1) << i;
    endcase
  endfunction

  task automatic do_read(input int m, input int h, input logic [19:0] w, input bit exp_err);
    int rises = 0, nv = 0, hi_run = 0, lo_run = 0, hi_bad = 0, lo_bad = 0, last_hi = 0;
    int exp_p, exp_hi;
    bit first_ok = 0, done = 0, fell_ready = 0;
    logic psclk = 1'b0, psdo;
    logic [31:0] got = '0, expv;
    longint sv;
    string rq;
    exp_p  = (m == 0) ? 25 : (m == 2) ? 21 : 26;
    exp_hi = (m < 2) ? HALF : (h == 0) ? 1 : h;
    rq     = (m == 0) ? "R4" : (m == 1) ? "R5" : (m == 2) ? "R6" : "R7";
    sv     = (w >= 20'h80000) ? longint'(w) - 1048576 : longint'(w);
    expv   = sv[31:0];
    next_word = w;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_mode = 2'(m); cmd_hold = 16'(h);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!timeout_err, "R8", "error clear on accept", timeout_err, 0);
    psdo = sdo;
    for (int c = 0; c < 8000; c++) begin
      @(negedge clk);
      if (sclk_out && !psclk) begin
        rises++;
        if (rises == 1) first_ok = !psdo;
        if (rises > 1 && lo_run != HALF) lo_bad++;
        hi_run = 0;
      end
      if (!sclk_out && psclk) begin
        last_hi = hi_run;
        if (rises < exp_p && hi_run != HALF) hi_bad++;
        if (rises == exp_p) fell_ready = cmd_ready;
        lo_run = 0;
      end
      if (sclk_out) hi_run++; else lo_run++;
      if (res_valid) begin nv++; got = res_data; end
      psclk = sclk_out; psdo = sdo;
      if (cmd_ready) begin done = 1; break; end
    end
    chk(done, rq, "returned to idle", done, 1);
    chk(rises == exp_p, rq, "pulse count", rises, exp_p);
    chk(first_ok, "R1", "first edge after line low", first_ok, 1);
    chk(hi_bad == 0 && lo_bad == 0, "R2", "phase lengths", hi_bad + lo_bad, 0);
    chk(nv == 1, "R3", "valid strobes", nv, 1);
    chk(got == expv, "R3", "result", got, expv);
    chk(last_hi == exp_hi, rq, "last high length", last_hi, exp_hi);
    if (m == 0) chk(fell_ready && sdo, "R4", "ready on last fall, line high",
                    {fell_ready, sdo}, 3);
    else if (!exp_err) chk(!fell_ready && !sdo, rq, "waited for line fall",
                           {fell_ready, sdo}, 0);
    chk(timeout_err == exp_err, "R8", "timeout flag", timeout_err, exp_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cmd_valid = 1'b0; cmd_mode = '0; cmd_hold = '0; mute = 1'b0; next_word = '0;
    repeat (4) @(negedge clk);
    chk(!sclk_out && cmd_ready && !res_valid && !timeout_err && res_data == 0,
        "R9", "reset state", {sclk_out, cmd_ready, res_valid, timeout_err}, 4);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 26; i++)
        do_read(m, (m >= 2) ? 13 + i : 0, pat(i), 1'b0);
    do_read(3, 0, 20'h12345, 1'b0);   // R7 zero hold
    mute = 1'b1;
    do_read(1, 0, 20'h0F0F0, 1'b1);   // R8 expiry
    mute = 1'b0;
    do_read(0, 0, 20'h80001, 1'b0);   // R8 cleared
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule